// File: doc/BRIEF.md
# SD Card Clock Enable Generator with Stop Gates

This block derives two clock-enable pulse trains from a parent clock for an SD host controller. One control register sets a two-stage division: a power-of-two source prescaler followed by a final stage that divides by 2 or by 4. `hs_ce` is the prescaler output and serves as the high-speed companion clock enable. `card_ce` is the final-stage output and serves as the card clock enable. Each enable is a single-cycle pulse, high once per output period. Each output has its own stop bit in the same register.

Software writes the encoded value directly. The block forces illegal prescaler codes to the largest legal code and reports this in an error bit. A strap input, `skip_fastest`, removes the divide-by-4 setting that uses the undivided source. Register writes reach the running divider only at the end of the current card-clock period. This prevents a shortened (runt) period when the rate changes or an output is started or stopped.

Top module: `sd_clkgen`

## Requirements
- R1: After reset, `rd_data` reads 0x0301 (both stop bits set, prescaler code 0, final code 1), or 0x0305 when `skip_fastest` is high (prescaler code 1). Neither enable pulses until a stop bit is cleared.
- R2: Register layout: bit 9 stops `hs_ce`, bit 8 stops `card_ce`, bits 4:2 hold the prescaler code, bits 1:0 hold the final-stage code, and bit 15 is the error flag. All other bits are ignored on write and read as 0.
- R3: The `card_ce` period in parent cycles is 2^p × f. Here p is the prescaler code and f is 4 when bit 0 of the final code is 1, or 2 when it is 0. Bit 1 of the final code is stored but has no effect.
- R4: With prescaler code 0 or 1 and the high-speed stop bit clear, `hs_ce` pulses once every 2^p cycles. It is high in every cycle in which `card_ce` is high, so it pulses f times per card period.
- R5: With prescaler code 2 or higher, `hs_ce` never pulses, whatever the stop bit holds.
- R6: A write with prescaler code 5, 6 or 7 stores code 4 and sets the error bit. Any write that needs no correction clears the error bit.
- R7: With `skip_fastest` high, a write of prescaler code 0 with final-code bit 0 set stores prescaler code 1 and sets the error bit. Other settings are stored unchanged.
- R8: A written setting takes effect only when the current card period ends. The interval from the last `card_ce` pulse before a write to the next pulse equals the old period, and the interval after that equals the new period.
- R9: While the card stop bit is set, `card_ce` does not pulse. After the bit is cleared, pulses resume at a period boundary with full-length periods.
- R10: The high-speed stop bit gates only `hs_ce`. `card_ce` keeps its period while `hs_ce` is stopped, and `hs_ce` keeps its period while `card_ce` is stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst | input | 1 | Synchronous active-high reset |
| skip_fastest | input | 1 | Strap that removes the divide-by-4 setting with an undivided source |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write value |
| rd_data | output | 16 | Register read value, including the error bit |
| card_ce | output | 1 | Card clock enable pulse |
| hs_ce | output | 1 | High-speed companion clock enable pulse |

## Verification
The bench moves from the slowest setting to the fastest in the middle of a period. A design that applied the new setting immediately would produce a shortened first interval instead of the full old period. It checks that the high-speed enable is silent for prescaler codes 2 and above. A design that gated only on the stop bit would leak companion pulses there. It writes prescaler codes above 4 and, in skip mode, the removed fastest setting. A design without correction would read back the raw value, give no error bit, or run at a period outside the legal set. It also checks each stop bit on its own, which catches swapped or shared gating.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

    localparam int REG_W       = 16;
    localparam int PRE_W       = 3;
    localparam int FIN_W       = 2;
    localparam int PRE_MAX     = 4;
    localparam int HS_PRE_MAX  = 1;
    localparam int FIN_SLOW    = 4;
    localparam int FIN_FAST    = 2;
    localparam int MAX_DIV     = (1 << PRE_MAX) * FIN_SLOW;
    localparam int CNT_W       = $clog2(MAX_DIV);

    localparam int FIN_LSB     = 0;
    localparam int PRE_LSB     = 2;
    localparam int STOP_CARD_B = 8;
    localparam int STOP_HS_B   = 9;
    localparam int ERR_B       = 15;

    typedef struct packed {
        logic             stop_hs;
        logic             stop_card;
        logic [PRE_W-1:0] pre;
        logic [FIN_W-1:0] fin;
    } clk_cfg_t;

    function automatic clk_cfg_t reset_cfg(input logic skip);
        clk_cfg_t c;
        c.stop_hs   = 1'b1;
        c.stop_card = 1'b1;
        c.pre       = skip ? PRE_W'(1) : PRE_W'(0);
        c.fin       = FIN_W'(1);
        return c;
    endfunction

    function automatic clk_cfg_t unpack_cfg(input logic [REG_W-1:0] w);
        clk_cfg_t c;
        c.stop_hs   = w[STOP_HS_B];
        c.stop_card = w[STOP_CARD_B];
        c.pre       = w[PRE_LSB +: PRE_W];
        c.fin       = w[FIN_LSB +: FIN_W];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_cfg(input clk_cfg_t c, input logic err);
        logic [REG_W-1:0] w;
        w                        = '0;
        w[STOP_HS_B]             = c.stop_hs;
        w[STOP_CARD_B]           = c.stop_card;
        w[PRE_LSB +: PRE_W]      = c.pre;
        w[FIN_LSB +: FIN_W]      = c.fin;
        w[ERR_B]                 = err;
        return w;
    endfunction

    function automatic logic [CNT_W-1:0] last_count(input clk_cfg_t c);
        int tot;
        tot = (c.fin[0] ? FIN_SLOW : FIN_FAST) << c.pre;
        return CNT_W'(tot - 1);
    endfunction

    function automatic logic [CNT_W-1:0] pre_mask(input clk_cfg_t c);
        return CNT_W'((1 << c.pre) - 1);
    endfunction

endpackage

// File: rtl/sdclk_cfg_reg.sv
module sdclk_cfg_reg
    import sdclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             skip,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output clk_cfg_t         pend,
    output logic             err
);

    clk_cfg_t legal_c;
    logic     legal_e;

    always_comb begin
        legal_c = unpack_cfg(wr_data);
        legal_e = 1'b0;
        if (int'(legal_c.pre) > PRE_MAX) begin
            legal_c.pre = PRE_W'(PRE_MAX);
            legal_e     = 1'b1;
        end
        if (skip && legal_c.pre == '0 && legal_c.fin[0]) begin
            legal_c.pre = PRE_W'(1);
            legal_e     = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= reset_cfg(skip);
            err  <= 1'b0;
        end else if (wr_en) begin
            pend <= legal_c;
            err  <= legal_e;
        end
    end

endmodule

// File: rtl/sdclk_div_core.sv
module sdclk_div_core
    import sdclk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     skip,
    input  clk_cfg_t pend,
    output clk_cfg_t act,
    output logic     wrap,
    output logic     card_ce,
    output logic     hs_ce
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mask;
    logic             hs_tick;

    assign mask    = pre_mask(act);
    assign wrap    = (cnt == last_count(act));
    assign hs_tick = ((cnt & mask) == mask);
    assign card_ce = wrap && !act.stop_card;
    assign hs_ce   = hs_tick && !act.stop_hs && (int'(act.pre) <= HS_PRE_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            act <= reset_cfg(skip);
        end else if (wrap) begin
            cnt <= '0;
            act <= pend;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/sd_clkgen.sv
module sd_clkgen
    import sdclk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        skip_fastest,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    output logic        card_ce,
    output logic        hs_ce
);

    clk_cfg_t pend_cfg;
    clk_cfg_t act_cfg;
    logic     cfg_err;
    logic     wrap;

    sdclk_cfg_reg i_cfg (
        .clk     (clk),
        .rst     (rst),
        .skip    (skip_fastest),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .pend    (pend_cfg),
        .err     (cfg_err)
    );

    sdclk_div_core i_core (
        .clk     (clk),
        .rst     (rst),
        .skip    (skip_fastest),
        .pend    (pend_cfg),
        .act     (act_cfg),
        .wrap    (wrap),
        .card_ce (card_ce),
        .hs_ce   (hs_ce)
    );

    assign rd_data = pack_cfg(pend_cfg, cfg_err);

endmodule

// File: rtl/sd_clkgen_checker.sv
module sd_clkgen_checker
    import sdclk_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        skip_fastest,
    input logic        card_ce,
    input logic        hs_ce,
    input logic        wrap,
    input clk_cfg_t    act_cfg,
    input logic [15:0] rd_data
);

    assert_card_gap_R3: assert property (@(posedge clk) disable iff (rst)
        card_ce |=> !card_ce);

    assert_card_with_hs_R4: assert property (@(posedge clk) disable iff (rst)
        (card_ce && !act_cfg.stop_hs && int'(act_cfg.pre) <= HS_PRE_MAX) |-> hs_ce);

    assert_hs_gated_R5: assert property (@(posedge clk) disable iff (rst)
        (int'(act_cfg.pre) > HS_PRE_MAX) |-> !hs_ce);

    assert_pre_legal_R6: assert property (@(posedge clk) disable iff (rst)
        int'(rd_data[4:2]) <= PRE_MAX);

    assert_skip_R7: assert property (@(posedge clk) disable iff (rst)
        skip_fastest |-> !(rd_data[4:2] == 3'd0 && rd_data[0]));

    assert_update_boundary_R8: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(act_cfg));

    assert_card_stop_R9: assert property (@(posedge clk) disable iff (rst)
        act_cfg.stop_card |-> !card_ce);

    assert_hs_stop_R10: assert property (@(posedge clk) disable iff (rst)
        act_cfg.stop_hs |-> !hs_ce);

endmodule

bind sd_clkgen sd_clkgen_checker i_chk (
    .clk          (clk),
    .rst          (rst),
    .skip_fastest (skip_fastest),
    .card_ce      (card_ce),
    .hs_ce        (hs_ce),
    .wrap         (wrap),
    .act_cfg      (act_cfg),
    .rd_data      (rd_data)
);

// File: tb/test_sd_clkgen.sv
module test_sd_clkgen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        skip_fastest = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        card_ce;
    logic        hs_ce;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sd_clkgen i_sd_clkgen (
        .clk          (clk),
        .rst          (rst),
        .skip_fastest (skip_fastest),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .card_ce      (card_ce),
        .hs_ce        (hs_ce)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic skip);
        @(negedge clk);
        skip_fastest = skip;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic measure(output int per, output int hsn);
        int n;
        per = 0;
        hsn = 0;
        n = 0;
        @(negedge clk);
        while (!card_ce && n < 150) begin
            @(negedge clk);
            n++;
        end
        if (card_ce) begin
            n = 0;
            do begin
                @(negedge clk);
                n++;
                if (hs_ce) hsn++;
            end while (!card_ce && n < 150);
            per = card_ce ? n : 0;
        end
    endtask

    task automatic count_window(input int cyc, output int cn, output int hn);
        cn = 0;
        hn = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (card_ce) cn++;
            if (hs_ce) hn++;
        end
    endtask

    task automatic apply_and_check(input string tag, input logic [15:0] v,
                                   input int exp_rd, input int exp_per, input int exp_hs);
        int per, hsn;
        wr(v);
        repeat (140) @(negedge clk);
        chk({tag, " readback"}, int'(rd_data), exp_rd);
        measure(per, hsn);
        chk({tag, " card period"}, per, exp_per);
        chk({tag, " hs pulses per card period"}, hsn, exp_hs);
    endtask

    task automatic test_reset_r1;
        int cn, hn;
        do_reset(1'b0);
        chk("R1 reset readback", int'(rd_data), 'h0301);
        count_window(100, cn, hn);
        chk("R1 no card pulses after reset", cn, 0);
        chk("R1 no hs pulses after reset", hn, 0);
    endtask

    task automatic test_rates_r3_r4_r5;
        apply_and_check("R3 R4 div4 pre0", 16'h0001, 'h0001, 4, 4);
        apply_and_check("R3 R4 div2 pre0", 16'h0000, 'h0000, 2, 2);
        apply_and_check("R3 R4 div8 pre1", 16'h0005, 'h0005, 8, 4);
        apply_and_check("R3 R4 div4 pre1 fin0", 16'h0004, 'h0004, 4, 2);
        apply_and_check("R3 R5 div16 pre2", 16'h0009, 'h0009, 16, 0);
        apply_and_check("R3 R5 div16 pre3 fin0", 16'h000C, 'h000C, 16, 0);
        apply_and_check("R3 R5 div32 pre4 fin0", 16'h0010, 'h0010, 32, 0);
        apply_and_check("R3 R5 div64 pre4", 16'h0011, 'h0011, 64, 0);
        apply_and_check("R3 fin bit1 ignored code2", 16'h0002, 'h0002, 2, 2);
        apply_and_check("R3 fin bit1 ignored code3", 16'h0003, 'h0003, 4, 4);
    endtask

    task automatic test_layout_r2;
        apply_and_check("R2 unused bits ignored", 16'h4020, 'h0000, 2, 2);
    endtask

    task automatic test_illegal_r6;
        apply_and_check("R6 pre7 forced to 4", 16'h001D, 'h8011, 64, 0);
        apply_and_check("R6 pre5 forced to 4 fin0", 16'h0014, 'h8010, 32, 0);
        apply_and_check("R6 legal write clears err", 16'h0005, 'h0005, 8, 4);
    endtask

    task automatic test_skip_r7;
        do_reset(1'b1);
        chk("R7 R1 reset readback in skip mode", int'(rd_data), 'h0305);
        apply_and_check("R7 fastest removed", 16'h0001, 'h8005, 8, 4);
        apply_and_check("R7 div2 allowed", 16'h0000, 'h0000, 2, 2);
        apply_and_check("R7 fin code3 pre0 removed", 16'h0003, 'h8007, 8, 4);
        do_reset(1'b0);
    endtask

    task automatic test_boundary_r8;
        int n1, n2;
        bit wrote;
        apply_and_check("R8 setup div64", 16'h0011, 'h0011, 64, 0);
        while (!card_ce) @(negedge clk);
        n1 = 0;
        wrote = 0;
        do begin
            @(negedge clk);
            n1++;
            if (n1 == 2) begin
                wr_en = 1'b1;
                wr_data = 16'h0000;
            end else if (n1 == 3) begin
                wr_en = 1'b0;
            end
        end while (!card_ce && n1 < 150);
        chk("R8 old period completes", n1, 64);
        n2 = 0;
        do begin
            @(negedge clk);
            n2++;
        end while (!card_ce && n2 < 150);
        chk("R8 new period after boundary", n2, 2);
    endtask

    task automatic test_stops_r9_r10;
        int cn, hn;
        apply_and_check("R10 hs stopped card runs", 16'h0201, 'h0201, 4, 0);
        wr(16'h0101);
        repeat (140) @(negedge clk);
        count_window(64, cn, hn);
        chk("R9 card stopped no card pulses", cn, 0);
        chk("R10 card stopped hs runs", hn, 64);
        wr(16'h0301);
        repeat (140) @(negedge clk);
        count_window(64, cn, hn);
        chk("R9 both stopped card", cn, 0);
        chk("R10 both stopped hs", hn, 0);
        apply_and_check("R9 card restart full period", 16'h0009, 'h0009, 16, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        test_reset_r1();
        test_rates_r3_r4_r5();
        test_layout_r2();
        test_illegal_r6();
        test_skip_r7();
        test_boundary_r8();
        test_stops_r9_r10();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule